// File: doc/BRIEF.md
# Delta-Panel Scan Timing Generator

This block produces the digital drive pulses for a small active-matrix panel whose dots sit in a delta arrangement. The panel has its own bidirectional horizontal and vertical shift registers. The block runs from one clock at twice the dot rate, so one tick is half a dot. It watches a horizontal and a vertical sync input and derives the following outputs:
- a vertical start pulse and a vertical step clock;
- a horizontal start pulse;
- a non-overlapping pair of horizontal shift clocks;
- three sample strobes for the video channels;
- a line-rate polarity flag;
- a blanking window and a side-black enable for the narrow aspect ratio.

The delta pattern places the dots of alternate lines 1.5 dots apart. For this reason, every odd line after a vertical sync shifts its whole horizontal sequence by `ODD_SHIFT` ticks. The default of 3 ticks equals 1.5 dots. The aspect-ratio, left/right and up/down inputs are taken only at a vertical sync edge. Inside the block they select the horizontal clock count and the strobe order. They are also presented to the panel as static direction levels.

In the text below, "tick 0" is the clock cycle that follows the clock edge at which a rising edge of `hsync_i` is first sampled. Line parity counts from the first line after a vertical sync edge, and that first line is even.

Top module: `dpt_scan_gen`

## Requirements
- R1: At the first hsync edge after a vsync edge, `vst_o` goes high for one line and `vck_o` is low. At each of the next `V_LINES` hsync edges, `vck_o` toggles. After that, `vck_o` holds until the next vsync edge, which clears it to low.
- R2: On each line, the horizontal clock window lasts `WIDE_COUNT*HCK_HALF` ticks in wide mode and `NARROW_COUNT*HCK_HALF` ticks in narrow mode. The window is split into slots of `HCK_HALF` ticks, and slot i carries one pulse. The pulse is on `hck1_o` when i is even and on `hck2_o` when i is odd. Each pulse is low for the first tick of its slot and high for the remaining ticks. This gives exactly WIDE_COUNT or NARROW_COUNT pulses per line.
- R3: `hck1_o` and `hck2_o` are never high in the same cycle.
- R4: `hst_o` rises at tick `H_DELAY` on even lines and at tick `H_DELAY+ODD_SHIFT` on odd lines. The line parity returns to even at every vsync edge.
- R5: `pol_o` inverts at every hsync edge and at no other time. Its reset value is 0.
- R6: `hst_o` stays high for `HST_SETUP+HST_HOLD` ticks. The horizontal clock window opens `HST_SETUP` ticks after `hst_o` rises, so `hst_o` falls `HST_HOLD` ticks after the window opens.
- R7: `wid_o`, `rgt_o` and `dwn_o` copy `wide_i`, `right_i` and `down_i` only at a vsync rising edge, and otherwise hold. The polarities are: wide = 1, narrow = 0; right scan = 1, left = 0; down scan = 1, up = 0. All three reset to 1.
- R8: `sh_o` uses bit 0 for channel 1, bit 1 for channel 2 and bit 2 for channel 3. Strobes fire only inside the window, at slot offsets 1, 2 and 3. For right scan the order is channel 2, channel 1, channel 3. For left scan it is channel 3, channel 1, channel 2.
- R9: `blank_o` is high exactly when the horizontal clock window is closed. `side_blk_o` equals `blank_o` in narrow mode and is 0 in wide mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the dot rate |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_i | input | 1 | Horizontal sync, rising edge starts a line |
| vsync_i | input | 1 | Vertical sync, rising edge starts a frame |
| wide_i | input | 1 | Aspect request, 1 = wide |
| right_i | input | 1 | Horizontal direction request, 1 = right |
| down_i | input | 1 | Vertical direction request, 1 = down |
| vst_o | output | 1 | Vertical start pulse |
| vck_o | output | 1 | Vertical step clock |
| hst_o | output | 1 | Horizontal start pulse |
| hck1_o | output | 1 | Horizontal clock phase 1 |
| hck2_o | output | 1 | Horizontal clock phase 2 |
| wid_o | output | 1 | Latched aspect level |
| rgt_o | output | 1 | Latched horizontal direction level |
| dwn_o | output | 1 | Latched vertical direction level |
| pol_o | output | 1 | Line polarity flag for video and side-black |
| blank_o | output | 1 | Horizontal clock window closed |
| side_blk_o | output | 1 | Side-black enable in narrow mode |
| sh_o | output | 3 | Sample strobes, channel 1 to 3 |

## Verification
A wrong line-parity bit shows up on the very next line: the start pulse, both clock phases and the strobes all land `ODD_SHIFT` ticks off. A per-tick comparison against the reference therefore catches it within a few ticks of the start pulse. A slip in the phase or slot state splits or merges pulses, which changes the per-line pulse count and the strobe positions within the same window. A vertical line counter that is off by one only shows as a wrong toggle total at the end of a frame. Errors in the latched mode state appear as the wrong window length or the wrong strobe order from the first line after the vsync edge.

// File: rtl/dpt_pkg.sv
package dpt_pkg;

  typedef struct packed {
    logic wide;
    logic right;
    logic down;
  } dpt_mode_t;

  // Tick at which the horizontal start pulse rises on a line of given parity.
  function automatic int hst_start(input int dly, input int shift, input logic odd);
    return odd ? dly + shift : dly;
  endfunction

  // Length of the horizontal clock window in ticks.
  function automatic int hck_span(input int count, input int half);
    return count * half;
  endfunction

  // Last tick any horizontal activity can reach, for counter sizing.
  function automatic int line_extent(input int dly, input int shift, input int su,
                                     input int ho, input int cw, input int cn,
                                     input int half);
    int big;
    big = (cw > cn) ? cw : cn;
    return dly + shift + su + ho + big * half + 2;
  endfunction

endpackage

// File: rtl/dpt_mode_latch.sv
module dpt_mode_latch
  import dpt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      vs_edge,
  input  dpt_mode_t mode_in,
  output dpt_mode_t mode_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '{wide: 1'b1, right: 1'b1, down: 1'b1};
    end else if (vs_edge) begin
      mode_q <= mode_in;
    end
  end

endmodule

// File: rtl/dpt_vscan.sv
module dpt_vscan #(
  parameter int V_LINES = 480
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vs_edge,
  input  logic hs_edge,
  output logic first_line,
  output logic vst_o,
  output logic vck_o
);

  localparam int VL_W = $clog2(V_LINES + 1);

  logic [VL_W-1:0] vline_q;
  logic            fresh_q;

  assign first_line = fresh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fresh_q <= 1'b0;
      vst_o   <= 1'b0;
      vck_o   <= 1'b0;
      vline_q <= VL_W'(V_LINES);
    end else if (vs_edge) begin
      fresh_q <= 1'b1;
      vck_o   <= 1'b0;
    end else if (hs_edge) begin
      if (fresh_q) begin
        fresh_q <= 1'b0;
        vst_o   <= 1'b1;
        vline_q <= '0;
      end else begin
        vst_o <= 1'b0;
        if (vline_q < VL_W'(V_LINES)) begin
          vck_o   <= ~vck_o;
          vline_q <= vline_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dpt_hscan.sv
module dpt_hscan
  import dpt_pkg::*;
#(
  parameter int WIDE_COUNT   = 357,
  parameter int NARROW_COUNT = 268,
  parameter int HCK_HALF     = 4,
  parameter int H_DELAY      = 16,
  parameter int ODD_SHIFT    = 3,
  parameter int HST_SETUP    = 2,
  parameter int HST_HOLD     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hs_edge,
  input  logic       first_line,
  input  logic       wide,
  input  logic       right,
  output logic       line_odd,
  output logic       win_act,
  output logic       hst_o,
  output logic       hck1_o,
  output logic       hck2_o,
  output logic       pol_o,
  output logic       blank_o,
  output logic       side_blk_o,
  output logic [2:0] sh_o
);

  localparam int MAX_END    = line_extent(H_DELAY, ODD_SHIFT, HST_SETUP, HST_HOLD,
                                          WIDE_COUNT, NARROW_COUNT, HCK_HALF);
  localparam int CNT_W      = $clog2(MAX_END + 1);
  localparam int PH_W       = $clog2(HCK_HALF);
  localparam int WIDE_LEN   = hck_span(WIDE_COUNT, HCK_HALF);
  localparam int NARROW_LEN = hck_span(NARROW_COUNT, HCK_HALF);

  logic [CNT_W-1:0] cnt_q;
  logic             on_q;
  logic             odd_q;
  logic             pol_q;
  logic [PH_W-1:0]  ph_q;
  logic             slot_odd_q;

  logic [CNT_W-1:0] start_t, win_beg, win_end, hst_end, win_len;
  logic             slot_wrap;

  assign line_odd = odd_q;
  assign pol_o    = pol_q;

  always_comb begin
    start_t = CNT_W'(hst_start(H_DELAY, ODD_SHIFT, odd_q));
    win_len = wide ? CNT_W'(WIDE_LEN) : CNT_W'(NARROW_LEN);
    win_beg = start_t + CNT_W'(HST_SETUP);
    win_end = win_beg + win_len;
    hst_end = start_t + CNT_W'(HST_SETUP + HST_HOLD);
  end

  assign win_act   = on_q && (cnt_q >= win_beg) && (cnt_q < win_end);
  assign slot_wrap = (ph_q == PH_W'(HCK_HALF - 1));

  // Tick counter, line parity and polarity
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      on_q  <= 1'b0;
      odd_q <= 1'b0;
      pol_q <= 1'b0;
    end else if (hs_edge) begin
      cnt_q <= '0;
      on_q  <= 1'b1;
      odd_q <= first_line ? 1'b0 : ~odd_q;
      pol_q <= ~pol_q;
    end else if (on_q && cnt_q != CNT_W'(MAX_END)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Slot phase engine inside the clock window
  always_ff @(posedge clk) begin
    if (!rst_n || hs_edge) begin
      ph_q       <= '0;
      slot_odd_q <= 1'b0;
    end else if (win_act) begin
      ph_q <= slot_wrap ? '0 : ph_q + 1'b1;
      if (slot_wrap) slot_odd_q <= ~slot_odd_q;
    end
  end

  assign hst_o      = on_q && (cnt_q >= start_t) && (cnt_q < hst_end);
  assign hck1_o     = win_act && !slot_odd_q && (ph_q != '0);
  assign hck2_o     = win_act &&  slot_odd_q && (ph_q != '0);
  assign blank_o    = !win_act;
  assign side_blk_o = !wide && !win_act;

  always_comb begin
    sh_o = 3'b000;
    if (win_act) begin
      if (ph_q == PH_W'(1))      sh_o = right ? 3'b010 : 3'b100;
      else if (ph_q == PH_W'(2)) sh_o = 3'b001;
      else if (ph_q == PH_W'(3)) sh_o = right ? 3'b100 : 3'b010;
    end
  end

endmodule

// File: rtl/dpt_scan_gen.sv
module dpt_scan_gen
  import dpt_pkg::*;
#(
  parameter int V_LINES      = 480,
  parameter int WIDE_COUNT   = 357,
  parameter int NARROW_COUNT = 268,
  parameter int HCK_HALF     = 4,
  parameter int H_DELAY      = 16,
  parameter int ODD_SHIFT    = 3,
  parameter int HST_SETUP    = 2,
  parameter int HST_HOLD     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hsync_i,
  input  logic       vsync_i,
  input  logic       wide_i,
  input  logic       right_i,
  input  logic       down_i,
  output logic       vst_o,
  output logic       vck_o,
  output logic       hst_o,
  output logic       hck1_o,
  output logic       hck2_o,
  output logic       wid_o,
  output logic       rgt_o,
  output logic       dwn_o,
  output logic       pol_o,
  output logic       blank_o,
  output logic       side_blk_o,
  output logic [2:0] sh_o
);

  logic      hs_prev, vs_prev;
  logic      hs_edge, vs_edge;
  logic      first_line, line_odd, win_act;
  dpt_mode_t mode_in, mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_prev <= 1'b0;
      vs_prev <= 1'b0;
    end else begin
      hs_prev <= hsync_i;
      vs_prev <= vsync_i;
    end
  end

  assign hs_edge = hsync_i && !hs_prev;
  assign vs_edge = vsync_i && !vs_prev;
  assign mode_in = '{wide: wide_i, right: right_i, down: down_i};

  dpt_mode_latch u_mode (
    .clk(clk), .rst_n(rst_n), .vs_edge(vs_edge), .mode_in(mode_in), .mode_q(mode_q)
  );

  dpt_vscan #(.V_LINES(V_LINES)) u_vscan (
    .clk(clk), .rst_n(rst_n), .vs_edge(vs_edge), .hs_edge(hs_edge),
    .first_line(first_line), .vst_o(vst_o), .vck_o(vck_o)
  );

  dpt_hscan #(
    .WIDE_COUNT(WIDE_COUNT), .NARROW_COUNT(NARROW_COUNT), .HCK_HALF(HCK_HALF),
    .H_DELAY(H_DELAY), .ODD_SHIFT(ODD_SHIFT), .HST_SETUP(HST_SETUP), .HST_HOLD(HST_HOLD)
  ) u_hscan (
    .clk(clk), .rst_n(rst_n), .hs_edge(hs_edge), .first_line(first_line),
    .wide(mode_q.wide), .right(mode_q.right), .line_odd(line_odd), .win_act(win_act),
    .hst_o(hst_o), .hck1_o(hck1_o), .hck2_o(hck2_o), .pol_o(pol_o),
    .blank_o(blank_o), .side_blk_o(side_blk_o), .sh_o(sh_o)
  );

  assign wid_o = mode_q.wide;
  assign rgt_o = mode_q.right;
  assign dwn_o = mode_q.down;

endmodule

// File: rtl/dpt_scan_chk.sv
module dpt_scan_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hs_edge,
  input logic       vs_edge,
  input logic       win_act,
  input logic       vck_o,
  input logic       hck1_o,
  input logic       hck2_o,
  input logic       wid_o,
  input logic       rgt_o,
  input logic       dwn_o,
  input logic       pol_o,
  input logic       blank_o,
  input logic       side_blk_o,
  input logic [2:0] sh_o
);

  AST_HCK_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(hck1_o && hck2_o)); // R3
  AST_VCK_ONLY_AT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_edge && !vs_edge) |=> $stable(vck_o)); // R1
  AST_POL_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    hs_edge |=> (pol_o != $past(pol_o))); // R5
  AST_POL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_edge |=> $stable(pol_o)); // R5
  AST_MODE_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_edge |=> $stable({wid_o, rgt_o, dwn_o})); // R7
  AST_HCK_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (hck1_o || hck2_o) |-> win_act); // R2
  AST_SH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sh_o)); // R8
  AST_SH_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_o != 3'b000) |-> !blank_o); // R8
  AST_SIDE_BLK_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    side_blk_o |-> (!wid_o && blank_o)); // R9

endmodule

bind dpt_scan_gen dpt_scan_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hs_edge(hs_edge), .vs_edge(vs_edge), .win_act(win_act),
  .vck_o(vck_o), .hck1_o(hck1_o), .hck2_o(hck2_o), .wid_o(wid_o), .rgt_o(rgt_o),
  .dwn_o(dwn_o), .pol_o(pol_o), .blank_o(blank_o), .side_blk_o(side_blk_o), .sh_o(sh_o)
);

// File: tb/test_dpt_scan_gen.sv
module test_dpt_scan_gen;

  localparam int CLK_PERIOD = 10;
  localparam int VL = 6, WC = 20, NC = 14, HH = 4, HD = 8, OS = 3, SU = 2, HO = 2;
  localparam int LINE_TICKS = 120;

  logic clk = 0, rst_n = 0, hsync = 0, vsync = 0, wide = 1, right = 1, down = 1;
  logic vst, vck, hst, hck1, hck2, wid, rgt, dwn, pol, blank, sb;
  logic [2:0] sh;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpt_scan_gen #(.V_LINES(VL), .WIDE_COUNT(WC), .NARROW_COUNT(NC), .HCK_HALF(HH),
    .H_DELAY(HD), .ODD_SHIFT(OS), .HST_SETUP(SU), .HST_HOLD(HO)) i_dpt_scan_gen (
    .clk(clk), .rst_n(rst_n), .hsync_i(hsync), .vsync_i(vsync), .wide_i(wide),
    .right_i(right), .down_i(down), .vst_o(vst), .vck_o(vck), .hst_o(hst),
    .hck1_o(hck1), .hck2_o(hck2), .wid_o(wid), .rgt_o(rgt), .dwn_o(dwn), .pol_o(pol),
    .blank_o(blank), .side_blk_o(sb), .sh_o(sh));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Behavioural reference state
  int  m_tick = 0, m_vl = VL;
  bit  m_on = 0, m_odd = 0, m_pol = 0, m_fresh = 0, m_vst = 0, m_vck = 0;
  bit  m_wide = 1, m_right = 1, m_down = 1, m_hsp = 0, m_vsp = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tick = 0; m_vl = VL; m_on = 0; m_odd = 0; m_pol = 0; m_fresh = 0;
      m_vst = 0; m_vck = 0; m_wide = 1; m_right = 1; m_down = 1; m_hsp = 0; m_vsp = 0;
    end else begin
      bit hs_e, vs_e;
      hs_e = hsync && !m_hsp;
      vs_e = vsync && !m_vsp;
      if (hs_e) begin
        m_tick = 0; m_on = 1; m_odd = m_fresh ? 0 : !m_odd; m_pol = !m_pol;
      end else if (m_on) m_tick++;
      if (vs_e) begin
        m_fresh = 1; m_vck = 0; m_wide = wide; m_right = right; m_down = down;
      end else if (hs_e) begin
        if (m_fresh) begin m_vst = 1; m_vl = 0; m_fresh = 0; end
        else begin
          m_vst = 0;
          if (m_vl < VL) begin m_vck = !m_vck; m_vl++; end
        end
      end
      m_hsp = hsync; m_vsp = vsync;
    end
  end

  // Per-cycle comparison and line-level counters
  int  pulses = 0, vck_toggles = 0;
  bit  p_hck = 0, p_vck = 0, p_hst = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int st, e0, len, k, ph;
      bit act, ev, e1, e2, ehst;
      logic [2:0] esh;
      st  = HD + (m_odd ? OS : 0);
      e0  = st + SU;
      len = (m_wide ? WC : NC) * HH;
      act = m_on && m_tick >= e0 && m_tick < e0 + len;
      k   = m_tick - e0;
      ph  = act ? k % HH : 0;
      ev  = ((k / HH) % 2) == 0;
      e1  = act && ev && ph != 0;
      e2  = act && !ev && ph != 0;
      ehst = m_on && m_tick >= st && m_tick < st + SU + HO;
      esh = 3'b000;
      if (act && ph == 1) esh = m_right ? 3'b010 : 3'b100;
      if (act && ph == 2) esh = 3'b001;
      if (act && ph == 3) esh = m_right ? 3'b100 : 3'b010;

      chk({vst, vck} == {m_vst, m_vck}, "R1 vst/vck", {vst, vck}, {m_vst, m_vck});
      chk({hck1, hck2} == {e1, e2}, "R2 hck pair", {hck1, hck2}, {e1, e2});
      chk(!(hck1 && hck2), "R3 overlap", {hck1, hck2}, 0);
      chk(hst == ehst, "R6 hst window", hst, ehst);
      chk(pol == m_pol, "R5 polarity", pol, m_pol);
      chk({wid, rgt, dwn} == {m_wide, m_right, m_down}, "R7 mode levels",
          {wid, rgt, dwn}, {m_wide, m_right, m_down});
      chk(sh == esh, "R8 strobes", sh, esh);
      chk({blank, sb} == {!act, !m_wide && !act}, "R9 blank/side", {blank, sb},
          {!act, !m_wide && !act});

      if (hst && !p_hst)
        chk(m_tick == st, m_odd ? "R4 odd-line start" : "R4 even-line start", m_tick, st);
      if ((hck1 || hck2) && !p_hck) pulses++;
      if (m_on && m_tick == e0 + len) begin
        chk(pulses == (m_wide ? WC : NC), "R2 pulses per line", pulses, m_wide ? WC : NC);
        pulses = 0;
      end
      if (vck != p_vck && vst == 0) vck_toggles++;
      p_hck = hck1 || hck2; p_vck = vck; p_hst = hst;
    end
  end

  task automatic do_line();
    hsync = 1; repeat (4) @(negedge clk);
    hsync = 0; repeat (LINE_TICKS - 4) @(negedge clk);
  endtask

  task automatic do_frame(input bit w, input bit r, input bit d);
    wide = w; right = r; down = d;
    vsync = 1; repeat (2) @(negedge clk);
    vsync = 0; repeat (2) @(negedge clk);
    vck_toggles = 0; pulses = 0;
    repeat (VL + 2) do_line();
    chk(vck_toggles == VL, "R1 vck steps per frame", vck_toggles, VL);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({vst, vck, hst, hck1, hck2, pol} == 6'b0, "R5 reset outputs low",
        {vst, vck, hst, hck1, hck2, pol}, 0);
    chk({wid, rgt, dwn, blank, sb} == 5'b11110, "R7 reset levels",
        {wid, rgt, dwn, blank, sb}, 5'b11110);
    rst_n = 1;
    @(negedge clk);
    do_frame(1, 1, 1);   // wide, right, down
    do_frame(0, 0, 0);   // narrow, left, up
    do_frame(0, 1, 1);   // narrow, right
    // Mode change mid-frame must not take effect (R7)
    wide = 1; right = 1; down = 1;
    vsync = 1; repeat (2) @(negedge clk); vsync = 0; repeat (2) @(negedge clk);
    vck_toggles = 0; pulses = 0;
    do_line(); do_line();
    wide = 0; right = 0; down = 0;
    repeat (VL) do_line();
    chk({wid, rgt, dwn} == 3'b111, "R7 mid-frame change ignored", {wid, rgt, dwn}, 3'b111);
    chk(vck_toggles == VL, "R1 vck steps per frame", vck_toggles, VL);
    do_frame(1, 0, 1);   // wide, left
    done = 1;
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    done = 1;
    report();
  end

endmodule